// File: doc/BRIEF.md
# Sequential Load/Store Line Merger

This block watches the pending requests of eight load/store units and groups those that can be served by one L1 line read. Each unit offers an address, a valid flag and a sequential flag. The sequential flag marks an address that a strided vector access generated as the next element after the one in the unit below. Because the flag already guarantees that neighbouring elements are in order, the merger does not compare full addresses between pairs of units. It compares only a few line-index bits above the 64-byte line offset, and those bits show when the sequence crosses into a new line.

A small state machine controls the handshake. In `ST_IDLE` the block waits for any valid request. On the transition `IDLE->HOLD` it captures a group mask and the line address, and it raises `issue_stb` for one cycle. In `ST_HOLD` it keeps the mask and the line address steady until the cache raises `line_accept`. On the transition `HOLD->DRAIN` it pulses `done_mask` so that the grouped units drop their requests. `ST_DRAIN` lasts one cycle, which gives the units time to clear. The transition `DRAIN->IDLE` then follows unconditionally.

Top module: `lsq_line_merger`

## Requirements
- R1: After reset, `issue_stb` is 0, `merge_mask` is 0 and `done_mask` is 0.
- R2: While no unit is valid, `issue_stb` stays 0.
- R3: A group always begins at the lowest-index valid unit, and that unit's bit is set in `merge_mask`.
- R4: If the first unit of a group is not sequential, `merge_mask` holds only that unit's bit.
- R5: If the first unit is sequential, the group extends upward over consecutive units that are valid, sequential and equal in address bits [9:6] to the first unit. It stops at the first unit that fails any of these conditions. Units above that point are left out even if they would match.
- R6: Address bits above bit 9 are not compared, so units that differ only there still merge.
- R7: `line_addr` equals the first unit's address with bits [5:0] set to zero.
- R8: `issue_stb` is high for exactly one cycle, in the first cycle of `ST_HOLD`. `merge_mask` and `line_addr` stay constant until the request is accepted.
- R9: `done_mask` equals `merge_mask` in a cycle where `line_accept` is high in `ST_HOLD`. In every other cycle it is zero.
- R10: Exactly one `ST_DRAIN` cycle separates an accept from the next `ST_IDLE`. With requests still pending, the next `issue_stb` comes two cycles after the accepting edge. `line_accept` outside `ST_HOLD` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 8 | Per-unit request pending |
| req_seq | input | 8 | Per-unit sequential-element flag |
| req_addr | input | 256 | Per-unit byte addresses, unit i at bits [32i+31:32i] |
| line_accept | input | 1 | Cache takes the offered line request |
| issue_stb | output | 1 | One-cycle pulse when a new group is offered |
| merge_mask | output | 8 | Units belonging to the offered group |
| line_addr | output | 32 | Line-aligned address of the group |
| done_mask | output | 8 | Units to clear, valid in the accepting cycle |

## Verification
The assertions assume that units behave like a request queue. A unit keeps its valid, flag and address constant until `done_mask` names it. A chain marked sequential really does step through one line in ascending order. The bench keeps to these assumptions: it changes unit inputs only on the falling edge after an accepting cycle, and it clears exactly the units named in `done_mask`. Its address patterns place each sequential run in ascending order within a line, except where a line crossing is the point of the test. The one deliberate exception is the high-bit test: there two flagged units differ in bits above bit 9, which the merger ignores by design.

// File: rtl/lsq_merge_pkg.sv
package lsq_merge_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_DRAIN = 2'd2
    } merge_state_e;
endpackage

// File: rtl/lsq_first_pick.sv
module lsq_first_pick #(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     valid,
    output logic [N-1:0]     first_oh,
    output logic [IDX_W-1:0] first_idx,
    output logic             any
);
    logic found;

    always_comb begin
        first_oh  = '0;
        first_idx = '0;
        found     = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (valid[i] && !found) begin
                found       = 1'b1;
                first_oh[i] = 1'b1;
                first_idx   = IDX_W'(i);
            end
        end
        any = found;
    end

    // R3
    always_comb begin
        one_pick_chk: assert ($onehot0(first_oh));
    end
endmodule

// File: rtl/lsq_group_scan.sv
module lsq_group_scan #(
    parameter int N      = 8,
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6,
    parameter int CMP_W  = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]        valid,
    input  logic [N-1:0]        seq,
    input  logic [N*ADDR_W-1:0] addr_flat,
    input  logic [IDX_W-1:0]    start_idx,
    output logic [N-1:0]        mask,
    output logic [ADDR_W-1:0]   line
);
    logic [ADDR_W-1:0] addr_arr [N];
    logic [ADDR_W-1:0] base;
    logic [N-1:0]      link;
    logic              run;

    assign base = addr_arr[start_idx];

    for (genvar g = 0; g < N; g++) begin : g_unit
        assign addr_arr[g] = addr_flat[g*ADDR_W +: ADDR_W];
        assign link[g] = valid[g] && seq[g] &&
                         (addr_arr[g][OFF_W +: CMP_W] == base[OFF_W +: CMP_W]);
    end

    always_comb begin
        mask = '0;
        run  = seq[start_idx];
        for (int i = 0; i < N; i++) begin
            if (i == int'(start_idx)) begin
                mask[i] = valid[i];
            end else if (i > int'(start_idx)) begin
                if (run && link[i]) mask[i] = 1'b1;
                else                run     = 1'b0;
            end
        end
    end

    assign line = {base[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
endmodule

// File: rtl/lsq_line_merger.sv
module lsq_line_merger #(
    parameter int N      = 8,
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6,
    parameter int CMP_W  = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        req_valid,
    input  logic [N-1:0]        req_seq,
    input  logic [N*ADDR_W-1:0] req_addr,
    input  logic                line_accept,
    output logic                issue_stb,
    output logic [N-1:0]        merge_mask,
    output logic [ADDR_W-1:0]   line_addr,
    output logic [N-1:0]        done_mask
);
    import lsq_merge_pkg::*;

    merge_state_e      state_q, state_d;
    logic [N-1:0]      mask_q, grp_mask, first_oh;
    logic [ADDR_W-1:0] line_q, grp_line;
    logic [IDX_W-1:0]  first_idx;
    logic              issue_q, any_req;

    lsq_first_pick #(.N(N)) pick_i (
        .valid     (req_valid),
        .first_oh  (first_oh),
        .first_idx (first_idx),
        .any       (any_req)
    );

    lsq_group_scan #(.N(N), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .CMP_W(CMP_W)) scan_i (
        .valid     (req_valid),
        .seq       (req_seq),
        .addr_flat (req_addr),
        .start_idx (first_idx),
        .mask      (grp_mask),
        .line      (grp_line)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (any_req)     state_d = ST_HOLD;
            ST_HOLD:  if (line_accept) state_d = ST_DRAIN;
            ST_DRAIN:                  state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
            line_q  <= '0;
            issue_q <= 1'b0;
        end else begin
            state_q <= state_d;
            issue_q <= (state_q == ST_IDLE) && any_req;
            if (state_q == ST_IDLE && any_req) begin
                mask_q <= grp_mask;
                line_q <= grp_line;
            end
        end
    end

    always_comb begin
        issue_stb  = issue_q;
        merge_mask = mask_q;
        line_addr  = line_q;
        done_mask  = (state_q == ST_HOLD && line_accept) ? mask_q : '0;
    end

    // R8
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_stb |=> !issue_stb);

    // R3
    stb_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_stb |-> (merge_mask != '0) && ((merge_mask & ~mask_q) == '0));

    // R7
    line_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_stb |-> (line_addr[OFF_W-1:0] == '0));

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !line_accept) |=> $stable(merge_mask) && $stable(line_addr));

    // R10
    drain_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_mask != '0) |=> (done_mask == '0) && !issue_stb);

    // R9
    done_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_mask != '0) |-> (done_mask == merge_mask));
endmodule

// File: tb/lsq_line_merger_tb.sv
module lsq_line_merger_tb_top;
    localparam int N = 8;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  v = '0, s = '0;
    logic [AW-1:0] a [N];
    logic [N*AW-1:0] a_flat;
    logic          acc = 1'b0;
    logic          issue_stb;
    logic [N-1:0]  merge_mask, done_mask;
    logic [AW-1:0] line_addr;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) a_flat[i*AW +: AW] = a[i];
    end

    lsq_line_merger dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(v), .req_seq(s), .req_addr(a_flat),
        .line_accept(acc), .issue_stb(issue_stb), .merge_mask(merge_mask),
        .line_addr(line_addr), .done_mask(done_mask)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_units();
        v = '0; s = '0;
        for (int i = 0; i < N; i++) a[i] = '0;
    endtask

    // one group: wait for strobe, check, accept, check done and drain
    task automatic run_round(input logic [N-1:0] exp_mask, input logic [AW-1:0] exp_line,
                             input int exp_k, input int hold_cycles, input string tag);
        int k;
        k = -1;
        for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            if (issue_stb) begin k = j; break; end
        end
        chk({tag, " R8 strobe seen"}, 64'(k >= 0), 64'd1);
        if (exp_k >= 0) chk({tag, " R10 strobe delay"}, 64'(k), 64'(exp_k));
        chk({tag, " R3/R5 mask"}, 64'(merge_mask), 64'(exp_mask));
        chk({tag, " R7 line"}, 64'(line_addr), 64'(exp_line));
        for (int h = 0; h < hold_cycles; h++) begin
            @(negedge clk);
            chk({tag, " R8 strobe low"}, 64'(issue_stb), 64'd0);
            chk({tag, " R8 mask held"}, 64'(merge_mask), 64'(exp_mask));
            chk({tag, " R9 no done"}, 64'(done_mask), 64'd0);
        end
        acc = 1'b1;
        #1;
        chk({tag, " R9 done"}, 64'(done_mask), 64'(exp_mask));
        @(negedge clk);
        acc = 1'b0;
        v = v & ~exp_mask;
        #1;
        chk({tag, " R10 drain no done"}, 64'(done_mask), 64'd0);
        chk({tag, " R10 drain no strobe"}, 64'(issue_stb), 64'd0);
    endtask

    task automatic t_reset();
        chk("R1 strobe", 64'(issue_stb), 64'd0);
        chk("R1 mask", 64'(merge_mask), 64'd0);
        chk("R1 done", 64'(done_mask), 64'd0);
    endtask

    task automatic t_idle();
        // R2 and R10: accept while idle does nothing
        acc = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk("R2 idle strobe", 64'(issue_stb), 64'd0);
            chk("R10 idle accept done", 64'(done_mask), 64'd0);
        end
        acc = 1'b0;
    endtask

    task automatic t_unmarked();
        clear_units();
        v = 8'h03; s = 8'h02;
        a[0] = 32'h0000_1000; a[1] = 32'h0000_1008;
        run_round(8'h01, 32'h0000_1000, -1, 0, "R4 unmarked");
        run_round(8'h02, 32'h0000_1000, 1, 0, "R3 next start");
    endtask

    task automatic t_group();
        clear_units();
        v = 8'h3C; s = 8'h3C;
        for (int i = 2; i < 6; i++) a[i] = 32'h1000_0100 + 32'((i - 2) * 8);
        run_round(8'h3C, 32'h1000_0100, -1, 2, "R5 group");
    endtask

    task automatic t_rollover();
        clear_units();
        v = 8'hFF; s = 8'hFF;
        for (int i = 0; i < N; i++) a[i] = 32'h2000_0020 + 32'(i * 8);
        run_round(8'h0F, 32'h2000_0000, -1, 0, "R5 rollover a");
        run_round(8'hF0, 32'h2000_0040, 1, 0, "R5 rollover b");
    endtask

    task automatic t_gap();
        clear_units();
        v = 8'h0B; s = 8'h0B;
        a[0] = 32'h3000_0000; a[1] = 32'h3000_0008; a[3] = 32'h3000_0018;
        run_round(8'h03, 32'h3000_0000, -1, 0, "R5 gap a");
        run_round(8'h08, 32'h3000_0000, 1, 0, "R5 gap b");
        clear_units();
        v = 8'h0F; s = 8'h0B;
        for (int i = 0; i < 4; i++) a[i] = 32'h3100_0000 + 32'(i * 8);
        run_round(8'h03, 32'h3100_0000, -1, 0, "R5 unmarked stop");
        run_round(8'h04, 32'h3100_0000, 1, 0, "R4 middle unmarked");
        run_round(8'h08, 32'h3100_0000, 1, 0, "R4 after unmarked");
    endtask

    task automatic t_highbits();
        clear_units();
        v = 8'h03; s = 8'h03;
        a[0] = 32'h0000_0000; a[1] = 32'hF000_0008;
        run_round(8'h03, 32'h0000_0000, -1, 0, "R6 high bits");
    endtask

    initial begin
        for (int i = 0; i < N; i++) a[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_idle();
        t_unmarked();
        t_group();
        t_rollover();
        t_gap();
        t_highbits();
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule